// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block gives a host a simple command interface for reading and writing 16-bit registers inside a PHY's control port. The PHY port has no clocked bus. Instead it has a 16-bit input word, four separate strobes (latch address, latch data, commit write, request read), one acknowledge line and a 16-bit output word. Every strobe is driven through a full four-phase exchange. The strobe rises and the master waits for acknowledge high. The strobe then falls and the master waits for acknowledge low.

The host issues one command at a time through a valid/ready pair. The command is an address-latch, a write, a read, or a power-down request. Completion is signalled by a one-cycle done pulse, which carries the read result and a timeout flag. Each wait for acknowledge is bounded by a fixed number of polls, spaced by a parameterised number of clock cycles. A write whose data word has its reset bit set is special: the PHY goes into reset and can no longer answer, so the commit strobe is fired without any wait. The power-down output is sticky and is cleared only by resetting the block.

Top module: `phy_ctl_master`

## Requirements
- R1: An address command (cmd_op = 2'b00) places cmd_word on phy_din, then performs one handshake on phy_cap_addr only, and ends with done high and err_timeout low.
- R2: A write command (cmd_op = 2'b01) whose bit 0 is clear performs a handshake on phy_cap_data and then a handshake on phy_wr, in that order, with cmd_word on phy_din. It ends without error.
- R3: A read command (cmd_op = 2'b10) performs one handshake on phy_rd. rd_data is the value of phy_dout sampled while phy_rd is high and the acknowledge is high.
- R4: A write command whose data bit 0 is set completes the phy_cap_data handshake, then raises phy_wr for a single cycle and finishes without waiting for any acknowledge. No timeout is reported, even when the acknowledge never rises again.
- R5: If the acknowledge does not rise within MAX_POLLS polls spaced POLL_CYCLES apart, the strobe is dropped and the command ends with err_timeout high in the done cycle. Done comes MAX_POLLS*POLL_CYCLES cycles after acceptance, to within two cycles.
- R6: If the acknowledge does not fall after a strobe is lowered, the command ends with err_timeout high.
- R7: At most one of the four strobes is high in any cycle, and phy_din does not change while a strobe is high.
- R8: cmd_ready is high only while the block is idle, no command is accepted while it is low, and done is high for exactly one cycle per command.
- R9: A power-down command (cmd_op = 2'b11) sets phy_pwrdn with no strobe activity. The output stays set through later commands until rst_n is asserted.
- R10: While rst_n is low the block is put in its reset state: cmd_ready high, done low, all strobes low, phy_pwrdn low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_op | input | 2 | 00 address, 01 write, 10 read, 11 power-down |
| cmd_word | input | DATA_W | Address or write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Result of the last read |
| err_timeout | output | 1 | Acknowledge wait expired (valid with done) |
| phy_din | output | DATA_W | Word presented to the PHY |
| phy_cap_addr | output | 1 | Latch-address strobe |
| phy_cap_data | output | 1 | Latch-data strobe |
| phy_wr | output | 1 | Commit-write strobe |
| phy_rd | output | 1 | Read-request strobe |
| phy_ack | input | 1 | PHY acknowledge |
| phy_dout | input | DATA_W | PHY read word |
| phy_pwrdn | output | 1 | Sticky power-down request |

## Verification
The hardest case to reach is the reset write. In this case the PHY stops answering partway through a command, and the master must still finish cleanly rather than time out. The behavioural responder in the bench reproduces it. When it sees the commit strobe rise with data bit 0 set, it forces its acknowledge low until the bench releases it. The bench then checks that no error was flagged and that completion came well inside the timeout window. Stuck-low and stuck-high acknowledge modes are used to reach the two timeout paths, once on the rising phase and once on the falling phase.

// File: rtl/phy_ctl_pkg.sv
// Shared types for the PHY control-port master.
// Assumes: two-bit host opcodes and four strobes, numbered as below.
package phy_ctl_pkg;
    localparam int NUM_STROBES = 4;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_PWRDN = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SB_CAPA = 2'd0,
        SB_CAPD = 2'd1,
        SB_WR   = 2'd2,
        SB_RD   = 2'd3
    } strobe_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI,
        ST_LO,
        ST_FIRE,
        ST_DONE
    } state_e;
endpackage

// File: rtl/phy_ack_waiter.sv
// Bounded poller for the acknowledge line.
// A start pulse arms it with the wanted level. Every POLL_CYCLES cycles it
// samples ack once. It reports hit on a match, or tmo after MAX_POLLS misses.
// Assumes: POLL_CYCLES >= 1, MAX_POLLS >= 1; start takes priority over a sample.
module phy_ack_waiter #(
    parameter int POLL_CYCLES = 4,
    parameter int MAX_POLLS   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic want_level,
    input  logic ack,
    output logic hit,
    output logic tmo
);
    localparam int CNT_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int TRY_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(POLL_CYCLES - 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_POLLS - 1);

    logic             active;
    logic             level_q;
    logic [CNT_W-1:0] cnt;
    logic [TRY_W-1:0] tries;
    logic             sample;

    // Sample point: the interval counter has run out.
    always_comb begin
        sample = active && (cnt == '0);
        hit    = sample && (ack == level_q);
        tmo    = sample && (ack != level_q) && (tries == TRY_LAST);
    end

    // Interval counter, attempt counter and armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            level_q <= 1'b0;
            cnt     <= '0;
            tries   <= '0;
        end else if (start) begin
            active  <= 1'b1;
            level_q <= want_level;
            cnt     <= CNT_LOAD;
            tries   <= '0;
        end else if (hit || tmo) begin
            active  <= 1'b0;
        end else if (sample) begin
            cnt     <= CNT_LOAD;
            tries   <= tries + 1'b1;
        end else if (active) begin
            cnt     <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/phy_strobe_dec.sv
// Turns a strobe selector and an enable into one-hot strobe lines.
// Assumes: the selector is held stable while enable is high.
module phy_strobe_dec
    import phy_ctl_pkg::*;
(
    input  logic                   en,
    input  strobe_e                sel,
    output logic [NUM_STROBES-1:0] lines
);
    // One decoder term per strobe line.
    for (genvar i = 0; i < NUM_STROBES; i++) begin : g_line
        assign lines[i] = en && (sel == strobe_e'(i));
    end
endmodule

// File: rtl/phy_ctl_master.sv
// Command sequencer for the PHY control port.
// It accepts one host command when idle and walks the strobe handshakes for it.
// Read data is captured while the read strobe is high. It finishes with a
// one-cycle done pulse and a timeout flag.
// Assumes: the PHY acknowledge is synchronous to clk; data bit RESET_BIT of a
// write is the PHY reset command.
module phy_ctl_master
    import phy_ctl_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int POLL_CYCLES = 4,
    parameter int MAX_POLLS   = 10,
    parameter int RESET_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_word,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_timeout,
    output logic [DATA_W-1:0] phy_din,
    output logic              phy_cap_addr,
    output logic              phy_cap_data,
    output logic              phy_wr,
    output logic              phy_rd,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_dout,
    output logic              phy_pwrdn
);
    state_e                 state, state_nx;
    strobe_e                sel, sel_nx;
    logic [DATA_W-1:0]      word_q;
    logic [DATA_W-1:0]      rd_q;
    logic                   err_q;
    logic                   pwr_q;
    logic                   w_start, w_level, w_hit, w_tmo;
    logic                   accept;
    logic                   strobe_en;
    logic [NUM_STROBES-1:0] lines;

    assign accept = (state == ST_IDLE) && cmd_valid;

    phy_ack_waiter #(
        .POLL_CYCLES(POLL_CYCLES),
        .MAX_POLLS  (MAX_POLLS)
    ) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (w_start),
        .want_level(w_level),
        .ack       (phy_ack),
        .hit       (w_hit),
        .tmo       (w_tmo)
    );

    // Next state, next strobe and waiter arming.
    always_comb begin
        state_nx = state;
        sel_nx   = sel;
        w_start  = 1'b0;
        w_level  = 1'b0;
        case (state)
            ST_IDLE: if (cmd_valid) begin
                if (op_e'(cmd_op) == OP_PWRDN) begin
                    state_nx = ST_DONE;
                end else begin
                    state_nx = ST_HI;
                    w_start  = 1'b1;
                    w_level  = 1'b1;
                    case (op_e'(cmd_op))
                        OP_ADDR:  sel_nx = SB_CAPA;
                        OP_WRITE: sel_nx = SB_CAPD;
                        default:  sel_nx = SB_RD;
                    endcase
                end
            end
            ST_HI: begin
                if (w_tmo) begin
                    state_nx = ST_DONE;
                end else if (w_hit) begin
                    state_nx = ST_LO;
                    w_start  = 1'b1;
                end
            end
            ST_LO: begin
                if (w_tmo) begin
                    state_nx = ST_DONE;
                end else if (w_hit) begin
                    if (sel == SB_CAPD) begin
                        sel_nx = SB_WR;
                        if (word_q[RESET_BIT]) begin
                            state_nx = ST_FIRE;
                        end else begin
                            state_nx = ST_HI;
                            w_start  = 1'b1;
                            w_level  = 1'b1;
                        end
                    end else begin
                        state_nx = ST_DONE;
                    end
                end
            end
            ST_FIRE: state_nx = ST_DONE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State and strobe selector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= SB_CAPA;
        end else begin
            state <= state_nx;
            sel   <= sel_nx;
        end
    end

    // Command word latch, read capture, error and sticky power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            rd_q   <= '0;
            err_q  <= 1'b0;
            pwr_q  <= 1'b0;
        end else begin
            if (accept) begin
                word_q <= cmd_word;
                err_q  <= 1'b0;
                if (op_e'(cmd_op) == OP_PWRDN) pwr_q <= 1'b1;
            end
            if ((state == ST_HI) && w_hit && (sel == SB_RD)) rd_q <= phy_dout;
            if (w_tmo) err_q <= 1'b1;
        end
    end

    assign strobe_en = (state == ST_HI) || (state == ST_FIRE);

    phy_strobe_dec u_dec (
        .en   (strobe_en),
        .sel  (sel),
        .lines(lines)
    );

    assign phy_cap_addr = lines[SB_CAPA];
    assign phy_cap_data = lines[SB_CAPD];
    assign phy_wr       = lines[SB_WR];
    assign phy_rd       = lines[SB_RD];
    assign phy_din      = word_q;
    assign phy_pwrdn    = pwr_q;
    assign cmd_ready    = (state == ST_IDLE);
    assign done         = (state == ST_DONE);
    assign err_timeout  = done && err_q;
    assign rd_data      = rd_q;
endmodule

// File: rtl/phy_ctl_master_chk.sv
// Property checker for the PHY control-port master, bound to every instance.
// Assumes: it sees the top-level ports only.
module phy_ctl_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              done,
    input logic              err_timeout,
    input logic [DATA_W-1:0] phy_din,
    input logic              phy_cap_addr,
    input logic              phy_cap_data,
    input logic              phy_wr,
    input logic              phy_rd,
    input logic              phy_pwrdn
);
    logic any_strobe;
    assign any_strobe = phy_cap_addr | phy_cap_data | phy_wr | phy_rd;

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}));

    a_r7_din_held: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strobe && $past(any_strobe)) |-> $stable(phy_din));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!any_strobe && !done));

    a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> done);

    a_r9_pwrdn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        phy_pwrdn |=> phy_pwrdn);
endmodule

bind phy_ctl_master phy_ctl_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .done        (done),
    .err_timeout (err_timeout),
    .phy_din     (phy_din),
    .phy_cap_addr(phy_cap_addr),
    .phy_cap_data(phy_cap_data),
    .phy_wr      (phy_wr),
    .phy_rd      (phy_rd),
    .phy_pwrdn   (phy_pwrdn)
);

// File: tb/tb_phy_ctl_master.sv
// Directed bench with a behavioural PHY responder.
// Responder acknowledge modes: 0 normal, 1 never acknowledges,
// 2 acknowledge sticks high once raised.
module tb_phy_ctl_master;
    localparam int DW = 16;
    localparam int P  = 4;
    localparam int M  = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [DW-1:0] cmd_word = '0;
    logic          cmd_ready, done, err_timeout;
    logic [DW-1:0] rd_data, phy_din, phy_dout;
    logic          phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_ack, phy_pwrdn;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    phy_ctl_master #(.DATA_W(DW), .POLL_CYCLES(P), .MAX_POLLS(M), .RESET_BIT(0)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_word(cmd_word), .done(done), .rd_data(rd_data),
        .err_timeout(err_timeout), .phy_din(phy_din), .phy_cap_addr(phy_cap_addr),
        .phy_cap_data(phy_cap_data), .phy_wr(phy_wr), .phy_rd(phy_rd),
        .phy_ack(phy_ack), .phy_dout(phy_dout), .phy_pwrdn(phy_pwrdn)
    );

    // ---------------- behavioural PHY responder ----------------
    int            mode = 0;
    bit            rst_release = 1'b0;
    bit            log_clear = 1'b0;
    logic [1:0]    ack_sr;
    logic          ack_hold;
    logic          in_reset;
    logic [3:0]    prev_sb;
    logic [15:0]   log_v;
    logic [DW-1:0] addr_lat;
    logic [DW-1:0] mem [16];
    logic          multi_seen, din_moved;
    logic [DW-1:0] prev_din;
    logic [3:0]    sb;

    assign sb = {phy_rd, phy_wr, phy_cap_data, phy_cap_addr};
    assign phy_ack = (mode == 1) ? 1'b0 :
                     (mode == 2) ? (ack_hold | ack_sr[1]) :
                     in_reset    ? 1'b0 : ack_sr[1];
    assign phy_dout = phy_rd ? mem[addr_lat[3:0]] : 16'hDEAD;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_sr <= '0; ack_hold <= 1'b0; in_reset <= 1'b0; prev_sb <= '0;
            log_v <= '0; addr_lat <= '0; multi_seen <= 1'b0; din_moved <= 1'b0;
            prev_din <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= 16'h1000 + 16'(i);
        end else begin
            ack_sr   <= {ack_sr[0], |sb};
            ack_hold <= (mode == 2) ? (ack_hold | ack_sr[1]) : 1'b0;
            prev_sb  <= sb;
            prev_din <= phy_din;
            if ($countones(sb) > 1) multi_seen <= 1'b1;
            if ((|sb) && (|prev_sb) && (phy_din != prev_din)) din_moved <= 1'b1;
            if (rst_release) in_reset <= 1'b0;
            if (log_clear) log_v <= '0;
            else if (sb[0] && !prev_sb[0]) log_v <= {log_v[11:0], 4'h1};
            else if (sb[1] && !prev_sb[1]) log_v <= {log_v[11:0], 4'h2};
            else if (sb[2] && !prev_sb[2]) log_v <= {log_v[11:0], 4'h3};
            else if (sb[3] && !prev_sb[3]) log_v <= {log_v[11:0], 4'h4};
            if (sb[0] && !prev_sb[0]) addr_lat <= phy_din;
            if (sb[2] && !prev_sb[2]) begin
                mem[addr_lat[3:0]] <= phy_din;
                if (phy_din[0]) in_reset <= 1'b1;
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Issue one command; return error, read data and cycles to done.
    task automatic issue(input logic [1:0] op, input logic [DW-1:0] w,
                         output logic err, output logic [DW-1:0] rd, output int lat);
        int n;
        @(negedge clk);
        log_clear = 1'b1;
        @(negedge clk);
        log_clear = 1'b0;
        cmd_valid = 1'b1; cmd_op = op; cmd_word = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        // R8: busy after acceptance (or already in its done cycle)
        check(!cmd_ready, "R8 ready low after accept", cmd_ready, 0);
        n = 1;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) check(1'b0, "watchdog done wait", n, 0);
        err = err_timeout; rd = rd_data; lat = n;
        @(negedge clk);
        check(!done, "R8 done single cycle", done, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(cmd_ready == 1'b1, "R10 ready in reset", cmd_ready, 1);
        check(done == 1'b0, "R10 done in reset", done, 0);
        check(sb == 4'h0, "R10 strobes in reset", sb, 0);
        check(phy_pwrdn == 1'b0, "R10 pwrdn in reset", phy_pwrdn, 0);
    endtask

    task automatic t_addr();
        logic e; logic [DW-1:0] r; int l;
        issue(2'b00, 16'h0005, e, r, l);
        check(e == 1'b0, "R1 no error", e, 0);
        check(log_v == 16'h0001, "R1 only cap_addr strobe", log_v, 16'h0001);
        check(addr_lat == 16'h0005, "R1 address on din", addr_lat, 16'h0005);
    endtask

    task automatic t_write_read();
        logic e; logic [DW-1:0] r; int l;
        issue(2'b01, 16'hBEE2, e, r, l);
        check(e == 1'b0, "R2 no error", e, 0);
        check(log_v == 16'h0023, "R2 cap_data then wr", log_v, 16'h0023);
        issue(2'b10, 16'h0000, e, r, l);
        check(e == 1'b0, "R3 no error", e, 0);
        check(log_v == 16'h0004, "R3 only rd strobe", log_v, 16'h0004);
        check(r == 16'hBEE2, "R3 read back written word", r, 16'hBEE2);
        issue(2'b00, 16'h0003, e, r, l);
        issue(2'b10, 16'h0000, e, r, l);
        check(r == 16'h1003, "R3 read untouched register", r, 16'h1003);
    endtask

    task automatic t_reset_write();
        logic e; logic [DW-1:0] r; int l;
        issue(2'b00, 16'h7F3F, e, r, l);
        issue(2'b01, 16'h0001, e, r, l);
        check(e == 1'b0, "R4 reset write no timeout", e, 0);
        check(log_v == 16'h0023, "R4 cap_data then wr", log_v, 16'h0023);
        check(in_reset == 1'b1, "R4 phy still silent", in_reset, 1);
        check(l < M * P, "R4 finished without ack wait", l, M * P);
        check(sb == 4'h0, "R4 strobes low after", sb, 0);
        @(negedge clk); rst_release = 1'b1;
        @(negedge clk); rst_release = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_timeout_rise();
        logic e; logic [DW-1:0] r; int l;
        mode = 1;
        issue(2'b10, 16'h0000, e, r, l);
        check(e == 1'b1, "R5 timeout flagged", e, 1);
        check(l >= M * P && l <= M * P + 2, "R5 timeout latency", l, M * P + 1);
        check(sb == 4'h0, "R5 strobe dropped", sb, 0);
        mode = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_timeout_fall();
        logic e; logic [DW-1:0] r; int l;
        mode = 2;
        issue(2'b00, 16'h0002, e, r, l);
        check(e == 1'b1, "R6 stuck-high ack timeout", e, 1);
        mode = 0;
        repeat (4) @(negedge clk);
        issue(2'b00, 16'h0002, e, r, l);
        check(e == 1'b0, "R6 error clears on next command", e, 0);
    endtask

    task automatic t_pwrdn();
        logic e; logic [DW-1:0] r; int l;
        issue(2'b11, 16'h0000, e, r, l);
        check(phy_pwrdn == 1'b1, "R9 pwrdn set", phy_pwrdn, 1);
        check(log_v == 16'h0000, "R9 no strobe for pwrdn", log_v, 0);
        issue(2'b00, 16'h0001, e, r, l);
        check(phy_pwrdn == 1'b1, "R9 pwrdn held over command", phy_pwrdn, 1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(phy_pwrdn == 1'b0, "R9 pwrdn cleared by reset", phy_pwrdn, 0);
        t_reset();
        rst_n = 1'b1;
    endtask

    task automatic t_r7_monitor();
        check(multi_seen == 1'b0, "R7 one strobe at a time", multi_seen, 0);
        check(din_moved == 1'b0, "R7 din held during strobe", din_moved, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_addr();
        t_write_read();
        t_reset_write();
        t_timeout_rise();
        t_timeout_fall();
        t_r7_monitor();
        t_pwrdn();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule